// File: doc/BRIEF.md
# Priority Throttle Vector Arbiter

This block decides which of several thermal or overcurrent throttle requests controls the clocks. Each throttle vector carries three programmed settings: a numeric priority, the percentage of CPU clock pulses to skip, and a 2-bit GPU throttle level code. Each vector also has a request line that is either on or off. On every cycle the block finds the requesting vector with the largest priority. It then passes that vector's CPU percentage and GPU level code to the pulse-skipping controls as one set, together with the vector's index and a valid flag.

The outputs are level controls, not a data stream. They are held in registers and follow the requests with one cycle of latency. They never wait for the consumer, so there is no back-pressure and no handshake. Both the requests and the configuration may change on any cycle. The new result appears after the next clock edge.

Top module: `thr_arbiter`

## Requirements
- R1: A vector takes part in arbitration only while its request bit is 1. A vector whose request bit is 0 never wins, whatever its settings.
- R2: Among the vectors taking part, the vector with the numerically largest priority wins. Its index appears on `win_idx` and `win_valid` is 1.
- R3: When two or more vectors taking part share the largest priority, the vector with the lowest index wins.
- R4: A priority of 0 disables a vector. Such a vector never wins, even while it requests. Useful priorities are 1 to 100, and any nonzero value is compared numerically.
- R5: The CPU skip percentage and the GPU level code on the outputs are both those of the winning vector, passed through unchanged.
- R6: The GPU level code is 2 bits wide: 0 = none (0%), 1 = low (50%), 2 = medium (75%), 3 = high (85%). All four codes pass through unchanged.
- R7: When no vector takes part, `win_valid` is 0, and `cpu_pct`, `gpu_lvl` and `win_idx` are all 0.
- R8: The outputs are registered. A change in the requests or the configuration shows on the outputs after exactly one rising clock edge, and not before it.
- R9: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | NUM_VEC | Per-vector request (1 = active) |
| cfg_prio | input | NUM_VEC*PRIO_W | Packed priorities, vector 0 in the low bits |
| cfg_cpu_pct | input | NUM_VEC*PCT_W | Packed CPU skip percentages, vector 0 in the low bits |
| cfg_gpu_lvl | input | NUM_VEC*2 | Packed GPU level codes, vector 0 in the low bits |
| cpu_pct | output | PCT_W | CPU skip percentage of the winner |
| gpu_lvl | output | 2 | GPU level code of the winner |
| win_idx | output | IDX_W | Index of the winning vector |
| win_valid | output | 1 | 1 when some vector wins |

## Verification
The assertions check on every cycle that the selected vector is requesting and has a nonzero priority. They also check that no requesting vector outranks the selected one, that a tie always resolves to the lower index, that the idle outputs are zero, and that the valid flag follows eligibility one cycle later. Only the bench scenarios can show that the exact percentage and level code of the right vector reach the pins. The same holds for all four level codes passing unchanged, for the outputs holding their old values until the clock edge, and for the chosen index agreeing with an independent model over random mixes of ties and disabled vectors.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int GPU_W = 2;

  typedef enum logic [GPU_W-1:0] {
    GPU_NONE = 2'd0,
    GPU_LOW  = 2'd1,
    GPU_MED  = 2'd2,
    GPU_HIGH = 2'd3
  } gpu_lvl_e;
endpackage

// File: rtl/thr_elig.sv
module thr_elig #(
  parameter int NUM_VEC = 4,
  parameter int PRIO_W  = 7
) (
  input  logic [NUM_VEC-1:0]        req,
  input  logic [NUM_VEC*PRIO_W-1:0] cfg_prio,
  output logic [NUM_VEC-1:0]        elig
);
  // A vector competes only when it requests and its priority is nonzero (R1, R4)
  for (genvar gi = 0; gi < NUM_VEC; gi++) begin : g_vec
    assign elig[gi] = req[gi] && (cfg_prio[gi*PRIO_W +: PRIO_W] != '0);
  end
endmodule

// File: rtl/thr_select.sv
module thr_select
  import thr_pkg::*;
#(
  parameter int NUM_VEC = 4,
  parameter int PRIO_W  = 7,
  parameter int PCT_W   = 7,
  localparam int IDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_VEC-1:0]        elig,
  input  logic [NUM_VEC*PRIO_W-1:0] cfg_prio,
  input  logic [NUM_VEC*PCT_W-1:0]  cfg_cpu_pct,
  input  logic [NUM_VEC*GPU_W-1:0]  cfg_gpu_lvl,
  output logic                      sel_valid,
  output logic [IDX_W-1:0]          sel_idx,
  output logic [PCT_W-1:0]          sel_cpu,
  output gpu_lvl_e                  sel_gpu
);
  // Linear chain: stage k holds the best among vectors 0..k-1
  logic              ch_v [NUM_VEC+1];
  logic [PRIO_W-1:0] ch_p [NUM_VEC+1];
  logic [IDX_W-1:0]  ch_i [NUM_VEC+1];
  logic [PCT_W-1:0]  ch_c [NUM_VEC+1];
  gpu_lvl_e          ch_g [NUM_VEC+1];

  assign ch_v[0] = 1'b0;
  assign ch_p[0] = '0;
  assign ch_i[0] = '0;
  assign ch_c[0] = '0;
  assign ch_g[0] = GPU_NONE;

  for (genvar gi = 0; gi < NUM_VEC; gi++) begin : g_stage
    logic [PRIO_W-1:0] p_here;
    logic              take;
    assign p_here = cfg_prio[gi*PRIO_W +: PRIO_W];
    // Strict compare keeps the earlier (lower) index on a tie (R3)
    assign take = elig[gi] && (!ch_v[gi] || (p_here > ch_p[gi]));
    assign ch_v[gi+1] = ch_v[gi] | take;
    assign ch_p[gi+1] = take ? p_here : ch_p[gi];
    assign ch_i[gi+1] = take ? IDX_W'(gi) : ch_i[gi];
    assign ch_c[gi+1] = take ? cfg_cpu_pct[gi*PCT_W +: PCT_W] : ch_c[gi];
    assign ch_g[gi+1] = take ? gpu_lvl_e'(cfg_gpu_lvl[gi*GPU_W +: GPU_W]) : ch_g[gi];

    // No requesting vector outranks the selection (R2)
    p_no_better_r2: assert property (@(posedge clk) disable iff (!rst_n)
      elig[gi] |-> (sel_valid && (p_here <= ch_p[NUM_VEC])));
    // Equal priority resolves to the lower index (R3)
    p_tie_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (elig[gi] && (p_here == ch_p[NUM_VEC])) |-> (sel_idx <= IDX_W'(gi)));
  end

  assign sel_valid = ch_v[NUM_VEC];
  assign sel_idx   = ch_i[NUM_VEC];
  assign sel_cpu   = ch_c[NUM_VEC];
  assign sel_gpu   = ch_g[NUM_VEC];

  // The selected vector is one that competes (R1)
  p_sel_eligible_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> elig[sel_idx]);
  // A disabled priority is never selected (R4)
  p_sel_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (cfg_prio[sel_idx*PRIO_W +: PRIO_W] != '0));
endmodule

// File: rtl/thr_outreg.sv
module thr_outreg
  import thr_pkg::*;
#(
  parameter int PCT_W = 7,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d_valid,
  input  logic [IDX_W-1:0] d_idx,
  input  logic [PCT_W-1:0] d_cpu,
  input  gpu_lvl_e         d_gpu,
  output logic             q_valid,
  output logic [IDX_W-1:0] q_idx,
  output logic [PCT_W-1:0] q_cpu,
  output gpu_lvl_e         q_gpu
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_idx   <= '0;
      q_cpu   <= '0;
      q_gpu   <= GPU_NONE;
    end else begin
      q_valid <= d_valid;
      q_idx   <= d_idx;
      q_cpu   <= d_cpu;
      q_gpu   <= d_gpu;
    end
  end
endmodule

// File: rtl/thr_arbiter.sv
module thr_arbiter
  import thr_pkg::*;
#(
  parameter int NUM_VEC = 4,
  parameter int PRIO_W  = 7,
  parameter int PCT_W   = 7,
  localparam int IDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_VEC-1:0]        req,
  input  logic [NUM_VEC*PRIO_W-1:0] cfg_prio,
  input  logic [NUM_VEC*PCT_W-1:0]  cfg_cpu_pct,
  input  logic [NUM_VEC*2-1:0]      cfg_gpu_lvl,
  output logic [PCT_W-1:0]          cpu_pct,
  output logic [1:0]                gpu_lvl,
  output logic [IDX_W-1:0]          win_idx,
  output logic                      win_valid
);
  logic [NUM_VEC-1:0] elig_w;
  logic               sel_valid_w;
  logic [IDX_W-1:0]   sel_idx_w;
  logic [PCT_W-1:0]   sel_cpu_w;
  gpu_lvl_e           sel_gpu_w;
  gpu_lvl_e           gpu_q;

  thr_elig #(.NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W)) u_elig (
    .req      (req),
    .cfg_prio (cfg_prio),
    .elig     (elig_w)
  );

  thr_select #(.NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W), .PCT_W(PCT_W)) u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .elig        (elig_w),
    .cfg_prio    (cfg_prio),
    .cfg_cpu_pct (cfg_cpu_pct),
    .cfg_gpu_lvl (cfg_gpu_lvl),
    .sel_valid   (sel_valid_w),
    .sel_idx     (sel_idx_w),
    .sel_cpu     (sel_cpu_w),
    .sel_gpu     (sel_gpu_w)
  );

  thr_outreg #(.PCT_W(PCT_W), .IDX_W(IDX_W)) u_oreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (sel_valid_w),
    .d_idx   (sel_idx_w),
    .d_cpu   (sel_cpu_w),
    .d_gpu   (sel_gpu_w),
    .q_valid (win_valid),
    .q_idx   (win_idx),
    .q_cpu   (cpu_pct),
    .q_gpu   (gpu_q)
  );

  assign gpu_lvl = gpu_q;

  // Idle outputs are all zero (R7)
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> (cpu_pct == '0 && gpu_lvl == 2'd0 && win_idx == '0));
  // Valid follows eligibility one edge later (R8)
  p_valid_late_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|elig_w) |=> win_valid);
  p_idle_late_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|elig_w) |=> !win_valid);
  // The winner requested on the previous cycle (R1)
  p_win_requested_r1: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> ((($past(req) >> win_idx) & NUM_VEC'(1)) != '0));
endmodule

// File: tb/tb_thr_arbiter.sv
`timescale 1ns/1ps
module tb_thr_arbiter;
  localparam int NV = 4;
  localparam int PW = 7;
  localparam int CW = 7;
  localparam int IW = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NV-1:0]  req = '0;
  logic [NV*PW-1:0] cfg_prio = '0;
  logic [NV*CW-1:0] cfg_cpu_pct = '0;
  logic [NV*2-1:0]  cfg_gpu_lvl = '0;
  logic [CW-1:0]  cpu_pct;
  logic [1:0]     gpu_lvl;
  logic [IW-1:0]  win_idx;
  logic           win_valid;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [PW-1:0] pr [NV];
  logic [CW-1:0] cp [NV];
  logic [1:0]    gl [NV];

  logic          e_v, p_v;
  logic [IW-1:0] e_i, p_i;
  logic [CW-1:0] e_c, p_c;
  logic [1:0]    e_g, p_g;

  always #2 clk = ~clk;

  thr_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req(req), .cfg_prio(cfg_prio),
    .cfg_cpu_pct(cfg_cpu_pct), .cfg_gpu_lvl(cfg_gpu_lvl),
    .cpu_pct(cpu_pct), .gpu_lvl(gpu_lvl), .win_idx(win_idx), .win_valid(win_valid)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Independent model of the requirements (R1-R7 semantics)
  task automatic model();
    e_v = 0; e_i = '0; e_c = '0; e_g = '0;
    for (int k = 0; k < NV; k++) begin
      if (req[k] && pr[k] != 0 && (!e_v || pr[k] > cfg_prio[e_i*PW +: PW])) begin
        e_v = 1; e_i = IW'(k); e_c = cp[k]; e_g = gl[k];
      end
    end
  endtask

  task automatic apply(string tag);
    @(negedge clk);
    for (int k = 0; k < NV; k++) begin
      cfg_prio[k*PW +: PW]    = pr[k];
      cfg_cpu_pct[k*CW +: CW] = cp[k];
      cfg_gpu_lvl[k*2 +: 2]   = gl[k];
    end
    p_v = e_v; p_i = e_i; p_c = e_c; p_g = e_g;
    model();
    #0.5;
    // R8: before the edge the outputs still show the previous result
    check({tag, " R8 hold valid"}, 16'(win_valid), 16'(p_v));
    check({tag, " R8 hold cpu"}, 16'(cpu_pct), 16'(p_c));
    @(posedge clk); #1;
    check({tag, " R2 valid"}, 16'(win_valid), 16'(e_v));
    check({tag, " R2 idx"}, 16'(win_idx), 16'(e_i));
    check({tag, " R5 cpu"}, 16'(cpu_pct), 16'(e_c));
    check({tag, " R6 gpu"}, 16'(gpu_lvl), 16'(e_g));
  endtask

  task automatic setv(int k, int p, int c, int g, bit r);
    pr[k] = PW'(p); cp[k] = CW'(c); gl[k] = 2'(g); req[k] = r;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    for (int k = 0; k < NV; k++) setv(k, 0, 0, 0, 0);
    e_v = 0; e_i = '0; e_c = '0; e_g = '0;
    // Reset state (R9)
    setv(0, 100, 85, 3, 1);
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset valid", 16'(win_valid), 16'd0);
    check("R9 reset cpu", 16'(cpu_pct), 16'd0);
    check("R9 reset gpu", 16'(gpu_lvl), 16'd0);
    check("R9 reset idx", 16'(win_idx), 16'd0);
    req = '0;
    @(negedge clk); rst_n = 1'b1;

    // R7: nothing requested
    apply("R7 idle");
    check("R7 idle cpu zero", 16'(cpu_pct), 16'd0);
    // R1: single vector, then idle vectors with high priority not requesting
    setv(0, 80, 50, 1, 1); setv(1, 100, 85, 3, 0);
    apply("R1 single");
    // R2: heavy over light
    req[1] = 1;
    apply("R2 heavy wins");
    check("R2 heavy idx direct", 16'(win_idx), 16'd1);
    check("R5 heavy cpu direct", 16'(cpu_pct), 16'd85);
    // R3: tie between 2 and 3 at top priority
    setv(1, 10, 20, 1, 1); setv(2, 90, 60, 2, 1); setv(3, 90, 70, 3, 1);
    apply("R3 tie");
    check("R3 tie picks idx2", 16'(win_idx), 16'd2);
    // R4: priority 0 requesting alone
    setv(0, 0, 99, 3, 1); req[1] = 0; req[2] = 0; req[3] = 0;
    apply("R4 zero prio");
    check("R4 zero prio not valid", 16'(win_valid), 16'd0);
    // R4: zero prio with low prio 1 present
    setv(3, 1, 5, 2, 1);
    apply("R4 prio1 beats zero");
    // R6: each GPU code passes through
    for (int g = 0; g < 4; g++) begin
      setv(3, 1, 5, g, 1);
      apply("R6 code");
      check("R6 code direct", 16'(gpu_lvl), 16'(g));
    end
    // Random mix with ties and disabled vectors
    for (int n = 0; n < 400; n++) begin
      for (int k = 0; k < NV; k++) begin
        int p;
        p = ($urandom % 4 == 0) ? int'($urandom % 3) : int'($urandom % 101);
        setv(k, p, int'($urandom % 101), int'($urandom % 4), bit'($urandom % 2));
      end
      apply("rnd R2 R3 R4 R5");
    end
    // R7 again after activity
    req = '0;
    apply("R7 return idle");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule